// File: doc/BRIEF.md
# UART FIFO Control and Receive Trigger

This block sits between a UART's serial shifters and the processor side. It holds a one-byte control register and two byte queues: one carries bytes the host writes toward the transmit shifter, the other carries bytes the receive shifter collects toward the host. The control byte selects between queued operation and single-byte holding operation. It also sets a receive trigger level, sets a flag that tells an external DMA engine which request style to use, and carries two one-shot flush commands. A receive interrupt is raised from the receive fill level against the selected trigger.

Every data path is valid/ready. A byte is taken on the push side only in a cycle where both `*_in_valid` and `*_in_ready` are high. The block does not stall the source. A byte offered while ready is low is discarded and leaves the queue unchanged, so a producer that must not lose data has to wait for ready. On the pop side a byte leaves in a cycle where both `*_out_valid` and `*_out_ready` are high. Asserting ready toward an empty queue does nothing, and the data output then keeps showing the byte that was popped most recently. The control write port, the interrupt enable and the status outputs are plain signals.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the control readback is 0x00, both counts are 0, the interrupt is low, the DMA flag is low and the block is in holding (non-queued) mode.
- R2: Control byte layout: bit 0 is queue enable, bit 1 is receive flush, bit 2 is transmit flush, bit 3 is the DMA flag, bits 7:6 are the trigger code, and bits 5:4 are unused. The readback shows enable, DMA flag and trigger code in those positions, and zeros in bits 5:4, 2 and 1.
- R3: A write with bit 0 = 1 stores the trigger code and DMA flag and turns queued mode on in that same cycle. A write with bit 0 = 0 leaves the trigger code and DMA flag unchanged, performs no flush command and selects holding mode.
- R4: Trigger codes 0, 1, 2 and 3 select 1, 4, 8 and 14 bytes. In queued mode `rx_irq` is high exactly when `rx_irq_en` is 1 and the receive count is at least the selected level. It drops in the cycle the count falls below that level.
- R5: In holding mode each queue holds at most one byte, and `rx_irq` is high when `rx_irq_en` is 1 and one receive byte is held.
- R6: A write that changes the enable bit empties both queues, so both counts read 0 on the following cycle.
- R7: A write with bit 0 = 1 and bit 2 = 1 empties only the transmit queue, and one with bit 1 = 1 empties only the receive queue. Writing 0 to these bits leaves the counts unchanged. The flush bits are never stored.
- R8: A flush takes priority over a push or pop in the same cycle. Neither happens, and `*_in_ready` is low during that cycle.
- R9: A push while full is dropped and does not change the count. A pop while empty keeps the count at 0, and `*_out_data` keeps the byte that was popped last (0 if none since reset).
- R10: In queued mode each queue holds 16 bytes and delivers them in arrival order. `*_count` reports the fill level.
- R11: `dma_mode` reflects the stored DMA flag, and `fifo_mode` reflects the stored enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control byte write strobe |
| cfg_wdata | input | 8 | Control byte written |
| cfg_rdata | output | 8 | Control readback |
| tx_in_valid | input | 1 | Host offers a transmit byte |
| tx_in_ready | output | 1 | Transmit queue can accept |
| tx_in_data | input | 8 | Transmit byte from host |
| tx_out_valid | output | 1 | Transmit byte available for the shifter |
| tx_out_ready | input | 1 | Shifter takes the transmit byte |
| tx_out_data | output | 8 | Head transmit byte |
| tx_count | output | 5 | Transmit fill level |
| rx_in_valid | input | 1 | Shifter offers a received byte |
| rx_in_ready | output | 1 | Receive queue can accept |
| rx_in_data | input | 8 | Received byte |
| rx_out_valid | output | 1 | Received byte available to host |
| rx_out_ready | input | 1 | Host takes the received byte |
| rx_out_data | output | 8 | Head received byte |
| rx_count | output | 5 | Receive fill level |
| rx_irq_en | input | 1 | Receive interrupt enable |
| rx_irq | output | 1 | Receive data-ready interrupt |
| dma_mode | output | 1 | Stored DMA flag |
| fifo_mode | output | 1 | Stored queue enable |

## Verification
The hardest case to reach is a flush command in a cycle where both queues also see a push and a pop. Only then does the priority of R8 decide the count. The stimulus first fills both queues part way, then holds valid and ready high on all four sides while writing both flush bits together. A reference model made of queues follows every cycle, and long stretches of mixed traffic with occasional random control writes also cross the enable transitions while data is in flight.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
  typedef enum logic [1:0] {
    TRIG_1  = 2'd0,
    TRIG_4  = 2'd1,
    TRIG_8  = 2'd2,
    TRIG_14 = 2'd3
  } rx_trig_e;

  typedef struct packed {
    rx_trig_e trig;
    logic     dma;
    logic     en;
  } ctl_t;

  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned RXFL_BIT  = 1;
  localparam int unsigned TXFL_BIT  = 2;
  localparam int unsigned DMA_BIT   = 3;
  localparam int unsigned TRIG_LSB  = 6;
endpackage

// File: rtl/ufc_ctrl_reg.sv
module ufc_ctrl_reg
  import ufc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output ctl_t       ctl,
  output logic       tx_flush,
  output logic       rx_flush,
  output logic [7:0] rdata
);
  logic prog;
  logic mode_flip;

  assign prog      = we && wdata[EN_BIT];
  assign mode_flip = we && (wdata[EN_BIT] != ctl.en);
  assign tx_flush  = (prog && wdata[TXFL_BIT]) || mode_flip;
  assign rx_flush  = (prog && wdata[RXFL_BIT]) || mode_flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (we) begin
      ctl.en <= wdata[EN_BIT];
      if (wdata[EN_BIT]) begin
        ctl.trig <= rx_trig_e'(wdata[TRIG_LSB +: 2]);
        ctl.dma  <= wdata[DMA_BIT];
      end
    end
  end

  assign rdata = {ctl.trig, 2'b00, ctl.dma, 2'b00, ctl.en};

  // R3
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !wdata[EN_BIT]) |=> ($stable(ctl.trig) && $stable(ctl.dma) && !ctl.en));
endmodule

// File: rtl/ufc_byte_fifo.sv
module ufc_byte_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned PW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          single,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [DW-1:0] last_q;
  logic [CW-1:0] limit;
  logic          push, pop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign limit     = single ? CW'(1) : CW'(DEPTH);
  assign in_ready  = !flush && (count < limit);
  assign push      = in_valid && in_ready;
  assign out_valid = (count != '0);
  assign pop       = out_valid && out_ready && !flush;
  assign out_data  = out_valid ? mem[rd_ptr] : last_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      last_q <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop) begin
        rd_ptr <= nxt(rd_ptr);
        last_q <= mem[rd_ptr];
      end
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R5
  single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single && $stable(single) && !$rose(rst_n)) |-> count <= CW'(1));
  // R7
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);
  // R9
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !pop && !flush) |=> $stable(count));
endmodule

// File: rtl/ufc_rx_trig.sv
module ufc_rx_trig
  import ufc_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  rx_trig_e      trig,
  input  logic          fifo_en,
  input  logic          irq_en,
  output logic          irq
);
  logic [CW-1:0] level;

  always_comb begin
    if (!fifo_en) begin
      level = CW'(1);
    end else begin
      case (trig)
        TRIG_1:  level = CW'(1);
        TRIG_4:  level = CW'(4);
        TRIG_8:  level = CW'(8);
        default: level = CW'(14);
      endcase
    end
  end

  assign irq = irq_en && (count >= level);

  // R4
  top_level_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && irq_en && count >= CW'(14)) |-> irq);
  // R5
  hold_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && irq_en && count != '0) |-> irq);
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import ufc_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [DW-1:0] tx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW-1:0] tx_out_data,
  output logic [CW-1:0] tx_count,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [DW-1:0] rx_in_data,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [DW-1:0] rx_out_data,
  output logic [CW-1:0] rx_count,
  input  logic          rx_irq_en,
  output logic          rx_irq,
  output logic          dma_mode,
  output logic          fifo_mode
);
  ctl_t ctl;
  logic tx_flush, rx_flush;

  ufc_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .ctl(ctl), .tx_flush(tx_flush), .rx_flush(rx_flush), .rdata(cfg_rdata)
  );

  ufc_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx_q (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .single(!ctl.en),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready), .out_data(tx_out_data),
    .count(tx_count)
  );

  ufc_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_q (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .single(!ctl.en),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_data(rx_in_data),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready), .out_data(rx_out_data),
    .count(rx_count)
  );

  ufc_rx_trig #(.CW(CW)) u_trig (
    .clk(clk), .rst_n(rst_n), .count(rx_count), .trig(ctl.trig),
    .fifo_en(ctl.en), .irq_en(rx_irq_en), .irq(rx_irq)
  );

  assign dma_mode  = ctl.dma;
  assign fifo_mode = ctl.en;
endmodule

// File: tb/uart_fifo_ctl_tb.sv
`timescale 1ns/1ps
module uart_fifo_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       tx_in_valid = 1'b0, tx_out_ready = 1'b0;
  logic [7:0] tx_in_data = '0;
  logic       tx_in_ready, tx_out_valid;
  logic [7:0] tx_out_data;
  logic [4:0] tx_count;
  logic       rx_in_valid = 1'b0, rx_out_ready = 1'b0;
  logic [7:0] rx_in_data = '0;
  logic       rx_in_ready, rx_out_valid;
  logic [7:0] rx_out_data;
  logic [4:0] rx_count;
  logic       rx_irq_en = 1'b0;
  logic       rx_irq, dma_mode, fifo_mode;

  always #4 clk = ~clk;

  uart_fifo_ctl u_dut (.*);

  int checks = 0;
  int fails = 0;
  string phase = "R1 reset";

  logic [7:0] txq[$];
  logic [7:0] rxq[$];
  logic [7:0] last_tx = '0, last_rx = '0;
  logic       m_en = 0, m_dma = 0;
  logic [1:0] m_trig = '0;

  function automatic int lvl(input logic [1:0] t);
    case (t)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", phase, what, act, exp);
    end
  endtask

  task automatic model_edge();
    bit flip, tclr, rclr;
    int cap, sz;
    flip = cfg_we && (cfg_wdata[0] != m_en);
    tclr = (cfg_we && cfg_wdata[0] && cfg_wdata[2]) || flip;
    rclr = (cfg_we && cfg_wdata[0] && cfg_wdata[1]) || flip;
    cap  = m_en ? 16 : 1;
    if (tclr) txq.delete();
    else begin
      sz = txq.size();
      if (tx_out_ready && sz > 0) last_tx = txq.pop_front();
      if (tx_in_valid && sz < cap) txq.push_back(tx_in_data);
    end
    if (rclr) rxq.delete();
    else begin
      sz = rxq.size();
      if (rx_out_ready && sz > 0) last_rx = rxq.pop_front();
      if (rx_in_valid && sz < cap) rxq.push_back(rx_in_data);
    end
    if (cfg_we) begin
      m_en = cfg_wdata[0];
      if (cfg_wdata[0]) begin
        m_trig = cfg_wdata[7:6];
        m_dma  = cfg_wdata[3];
      end
    end
  endtask

  task automatic check_all();
    bit flip, tclr, rclr;
    int cap, irq_lvl;
    flip = cfg_we && (cfg_wdata[0] != m_en);
    tclr = (cfg_we && cfg_wdata[0] && cfg_wdata[2]) || flip;
    rclr = (cfg_we && cfg_wdata[0] && cfg_wdata[1]) || flip;
    cap  = m_en ? 16 : 1;
    irq_lvl = m_en ? lvl(m_trig) : 1;
    chk("tx_in_ready",  tx_in_ready,  (!tclr && txq.size() < cap));
    chk("tx_out_valid", tx_out_valid, txq.size() > 0);
    chk("tx_out_data",  tx_out_data,  txq.size() > 0 ? txq[0] : last_tx);
    chk("tx_count",     tx_count,     txq.size());
    chk("rx_in_ready",  rx_in_ready,  (!rclr && rxq.size() < cap));
    chk("rx_out_valid", rx_out_valid, rxq.size() > 0);
    chk("rx_out_data",  rx_out_data,  rxq.size() > 0 ? rxq[0] : last_rx);
    chk("rx_count",     rx_count,     rxq.size());
    chk("rx_irq",       rx_irq,       rx_irq_en && rxq.size() >= irq_lvl);
    chk("dma_mode",     dma_mode,     m_dma);
    chk("fifo_mode",    fifo_mode,    m_en);
    chk("cfg_rdata",    cfg_rdata,    {m_trig, 2'b00, m_dma, 2'b00, m_en});
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #2;
    check_all();
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_we = 1'b1;
    cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic push_rx(input int n);
    for (int i = 0; i < n; i++) begin
      rx_in_valid = 1'b1;
      rx_in_data  = rx_in_data + 8'd1;
      step();
    end
    rx_in_valid = 1'b0;
  endtask

  task automatic pop_rx(input int n);
    rx_out_ready = 1'b1;
    for (int i = 0; i < n; i++) step();
    rx_out_ready = 1'b0;
  endtask

  task automatic push_tx(input int n);
    for (int i = 0; i < n; i++) begin
      tx_in_valid = 1'b1;
      tx_in_data  = tx_in_data + 8'd3;
      step();
    end
    tx_in_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired in phase %s", phase);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    phase = "R1 reset state";
    check_all();
    step();

    phase = "R5 holding mode single byte";
    rx_irq_en = 1'b1;
    push_rx(3);
    push_tx(2);
    phase = "R9 pop beyond empty keeps last";
    pop_rx(3);
    tx_out_ready = 1'b1; step(); step(); tx_out_ready = 1'b0;

    phase = "R3 write with enable low discarded";
    wr(8'hCE);
    step();

    phase = "R2 layout and same cycle program";
    wr(8'hC9);
    phase = "R11 dma and mode flags";
    step();

    phase = "R10 fill order and depth";
    push_rx(18);
    push_tx(17);
    phase = "R4 trigger 14 drop";
    pop_rx(5);
    phase = "R9 pop empty";
    pop_rx(14);
    tx_out_ready = 1'b1;
    for (int i = 0; i < 18; i++) step();
    tx_out_ready = 1'b0;

    phase = "R4 trigger table";
    for (int c = 0; c < 4; c++) begin
      wr({c[1:0], 6'b001001});
      push_rx(15);
      pop_rx(16);
    end
    rx_irq_en = 1'b0;
    push_rx(5);
    rx_irq_en = 1'b1;
    step();

    phase = "R7 single side flush";
    push_tx(4);
    wr(8'h05);
    push_tx(3);
    wr(8'h03);
    push_rx(2);
    wr(8'h01);
    step();

    phase = "R8 flush beats push and pop";
    push_tx(3);
    push_rx(4);
    tx_in_valid = 1'b1; tx_out_ready = 1'b1;
    rx_in_valid = 1'b1; rx_out_ready = 1'b1;
    wr(8'h87);
    step();
    tx_in_valid = 1'b0; tx_out_ready = 1'b0;
    rx_in_valid = 1'b0; rx_out_ready = 1'b0;
    step();

    phase = "R6 enable change flushes";
    push_tx(5);
    push_rx(6);
    wr(8'h00);
    push_rx(2);
    wr(8'h41);
    push_rx(3);
    step();

    phase = "R6 mixed traffic";
    for (int i = 0; i < 800; i++) begin
      tx_in_valid  = $urandom_range(0, 3) != 0;
      tx_in_data   = 8'($urandom);
      tx_out_ready = $urandom_range(0, 2) == 0;
      rx_in_valid  = $urandom_range(0, 3) != 0;
      rx_in_data   = 8'($urandom);
      rx_out_ready = $urandom_range(0, 2) == 0;
      rx_irq_en    = $urandom_range(0, 7) != 0;
      cfg_we       = $urandom_range(0, 29) == 0;
      cfg_wdata    = 8'($urandom);
      if ($urandom_range(0, 3) != 0) cfg_wdata[0] = 1'b1;
      step();
    end
    cfg_we = 1'b0;
    tx_in_valid = 1'b0; rx_in_valid = 1'b0;
    tx_out_ready = 1'b0; rx_out_ready = 1'b0;
    step();
    finish_run();
  end
endmodule